// File: doc/BRIEF.md
# Memory Ordering Fence Dispatch Gate

This block sits between an in-order allocation stage and the execution ports and decides, every cycle, whether the micro-op offered by allocation may dispatch. When a store-load barrier, an atomic read-modify-write or a full fence has been dispatched, the gate holds back the younger operations that the barrier must order. It keeps granting the ones the barrier does not order. The store buffer is never pushed or flushed. The gate only waits for the store-buffer-empty indication, which rises when older stores have drained through normal operation.

The offered op is dispatched in a cycle when `in_valid` and `in_ready` are both high. `alloc_stall` tells allocation to hold the op at its output. Only one barrier is tracked at a time, so a second barrier offered while one is pending is held like any other memory op. A run of non-memory ops after a barrier passes without stalling. Allocation stalls only at the first load or store, except behind a full fence, which blocks every op until it retires.

The controller has six states:
- IDLE: nothing pending.
- SL_ALL: store-load barrier pending, holding loads and stores.
- SL_LD: store-load barrier pending, holding loads only.
- ATOMIC: atomic pending.
- FF_WAIT: full fence not yet retired.
- FF_DRAIN: full fence retired, stores still draining.

It has these transitions:
- IDLE→ATOMIC, IDLE→SL_ALL, IDLE→SL_LD and IDLE→FF_WAIT, each when the matching barrier is dispatched.
- SL_ALL/SL_LD/ATOMIC→IDLE on store-buffer-empty.
- FF_WAIT→IDLE on retire together with store-buffer-empty.
- FF_WAIT→FF_DRAIN on retire while stores remain.
- FF_DRAIN→IDLE on store-buffer-empty.

Top module: `fence_dispatch_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no barrier is pending, so a valid load, store or non-memory op is dispatched.
- R2: `in_kind` encodes 0 other, 1 load, 2 store, 3 atomic, 4 store-load barrier, 5 full fence, 6 and 7 other. `dispatch` = `in_valid` & `in_ready` and `alloc_stall` = `in_valid` & !`in_ready`. With nothing pending, every kind is dispatched.
- R3: A store-load barrier dispatched with `hold_loads_only` low stalls younger loads and stores. Non-memory ops (kinds 0, 6, 7) are dispatched.
- R4: A store-load barrier dispatched with `hold_loads_only` high stalls younger loads, and younger stores and non-memory ops are dispatched.
- R5: While an atomic is pending, loads and stores stall and non-memory ops are dispatched.
- R6: While a full fence has not retired, every op stalls, even with `sb_empty` high.
- R7: After a full fence retires with `sb_empty` low, loads and stores stall and non-memory ops are dispatched.
- R8: A store-load barrier or atomic clears in the cycle after `sb_empty` is sampled high. A full fence clears in the cycle after `sb_empty` is sampled high with retirement seen in that cycle or earlier. Stalled ops are dispatched from the next cycle on.
- R9: A barrier (kind 3, 4 or 5) offered while any barrier is pending stalls.
- R10: `bar_retire` has no effect unless a full fence is pending. This holds for a pulse in IDLE and for a pulse while a store-load barrier or atomic is pending.
- R11: The hold mode is captured when the store-load barrier is dispatched. Changes on `hold_loads_only` while it is pending have no effect.
- R12: A barrier stays pending for at least one cycle. `sb_empty` high in its own dispatch cycle does not clear it, so a load offered in the next cycle stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Allocation offers an op |
| in_kind | input | 3 | Op kind code (see R2) |
| hold_loads_only | input | 1 | Hold mode for a store-load barrier, captured at its dispatch |
| sb_empty | input | 1 | Store buffer has drained |
| bar_retire | input | 1 | The pending full fence retires |
| in_ready | output | 1 | Offered op may dispatch this cycle |
| dispatch | output | 1 | Op dispatched to the execution ports |
| alloc_stall | output | 1 | Allocation must hold its op |

## Verification
The situation hardest to reach from the ports is FF_DRAIN, where the full fence has retired but stores have not drained. It exists only while `bar_retire` is pulsed with `sb_empty` held low. The stimulus gets there by dispatching a full fence, pulsing retirement with the store buffer still busy, and then sweeping all eight kinds against it. A second sweep pulses retirement and empty together to show the direct exit. Every barrier kind, in both hold modes, is followed by a full sweep of kinds. During that sweep the mode input is inverted and retirement is pulsed, to show that both are ignored.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
    localparam int KIND_W  = 3;
    localparam int STATE_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_OTHER     = 3'd0,
        K_LOAD      = 3'd1,
        K_STORE     = 3'd2,
        K_ATOMIC    = 3'd3,
        K_SLFENCE   = 3'd4,
        K_FULLFENCE = 3'd5,
        K_SPARE6    = 3'd6,
        K_SPARE7    = 3'd7
    } op_kind_e;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_SL_ALL   = 3'd1,
        ST_SL_LD    = 3'd2,
        ST_ATOMIC   = 3'd3,
        ST_FF_WAIT  = 3'd4,
        ST_FF_DRAIN = 3'd5
    } gate_state_e;

    typedef struct packed {
        logic ld;
        logic st;
        logic bar_at;
        logic bar_sl;
        logic bar_ff;
    } op_class_t;
endpackage

// File: rtl/fgate_decode.sv
module fgate_decode
    import fgate_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    output op_class_t         cls
);
    always_comb begin
        cls = '0;
        unique case (op_kind_e'(kind))
            K_LOAD:      cls.ld     = 1'b1;
            K_STORE:     cls.st     = 1'b1;
            K_ATOMIC:    cls.bar_at = 1'b1;
            K_SLFENCE:   cls.bar_sl = 1'b1;
            K_FULLFENCE: cls.bar_ff = 1'b1;
            default:     cls        = '0;
        endcase
    end
endmodule

// File: rtl/fgate_fsm.sv
module fgate_fsm
    import fgate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  op_class_t   cls,
    input  logic        hold_loads_only,
    input  logic        sb_empty,
    input  logic        bar_retire,
    output gate_state_e state
);
    gate_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (take && cls.bar_at)      nxt = ST_ATOMIC;
                else if (take && cls.bar_sl) nxt = hold_loads_only ? ST_SL_LD : ST_SL_ALL;
                else if (take && cls.bar_ff) nxt = ST_FF_WAIT;
            end
            ST_SL_ALL, ST_SL_LD, ST_ATOMIC: begin
                if (sb_empty) nxt = ST_IDLE;
            end
            ST_FF_WAIT: begin
                if (bar_retire && sb_empty) nxt = ST_IDLE;
                else if (bar_retire)        nxt = ST_FF_DRAIN;
            end
            ST_FF_DRAIN: begin
                if (sb_empty) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/fgate_gate.sv
module fgate_gate
    import fgate_pkg::*;
(
    input  gate_state_e state,
    input  op_class_t   cls,
    input  logic        in_valid,
    output logic        in_ready,
    output logic        dispatch,
    output logic        alloc_stall
);
    logic is_bar;
    logic is_mem;

    always_comb begin
        is_bar = cls.bar_at | cls.bar_sl | cls.bar_ff;
        is_mem = cls.ld | cls.st | is_bar;
        unique case (state)
            ST_IDLE:     in_ready = 1'b1;
            ST_SL_ALL:   in_ready = !is_mem;
            ST_SL_LD:    in_ready = !(cls.ld | is_bar);
            ST_ATOMIC:   in_ready = !is_mem;
            ST_FF_WAIT:  in_ready = 1'b0;
            ST_FF_DRAIN: in_ready = !is_mem;
            default:     in_ready = 1'b1;
        endcase
        dispatch    = in_valid & in_ready;
        alloc_stall = in_valid & ~in_ready;
    end
endmodule

// File: rtl/fence_dispatch_gate.sv
module fence_dispatch_gate
    import fgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [KIND_W-1:0] in_kind,
    input  logic              hold_loads_only,
    input  logic              sb_empty,
    input  logic              bar_retire,
    output logic              in_ready,
    output logic              dispatch,
    output logic              alloc_stall
);
    op_class_t   cls;
    gate_state_e cur_state;

    fgate_decode u_dec (
        .kind (in_kind),
        .cls  (cls)
    );

    fgate_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .take            (dispatch),
        .cls             (cls),
        .hold_loads_only (hold_loads_only),
        .sb_empty        (sb_empty),
        .bar_retire      (bar_retire),
        .state           (cur_state)
    );

    fgate_gate u_gate (
        .state       (cur_state),
        .cls         (cls),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .dispatch    (dispatch),
        .alloc_stall (alloc_stall)
    );
endmodule

// File: rtl/fgate_checker.sv
module fgate_checker
    import fgate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [KIND_W-1:0] in_kind,
    input logic              sb_empty,
    input logic              dispatch,
    input logic              alloc_stall,
    input gate_state_e       cur_state
);
    logic k_nonmem;
    logic k_bar;
    assign k_nonmem = (in_kind == 3'd0) || (in_kind == 3'd6) || (in_kind == 3'd7);
    assign k_bar    = (in_kind == 3'd3) || (in_kind == 3'd4) || (in_kind == 3'd5);

    p_idle_grants_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && in_valid) |-> dispatch);

    p_load_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_state == ST_SL_ALL || cur_state == ST_SL_LD) && in_valid && in_kind == 3'd1) |-> alloc_stall);

    p_store_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_SL_LD && in_valid && in_kind == 3'd2) |-> dispatch);

    p_nonmem_flows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_state == ST_SL_ALL || cur_state == ST_SL_LD || cur_state == ST_ATOMIC ||
          cur_state == ST_FF_DRAIN) && in_valid && k_nonmem) |-> dispatch);

    p_fence_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_FF_WAIT && in_valid) |-> alloc_stall);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_state == ST_SL_ALL || cur_state == ST_SL_LD || cur_state == ST_ATOMIC) && sb_empty)
        |=> (cur_state == ST_IDLE));

    p_second_bar_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != ST_IDLE && in_valid && k_bar) |-> alloc_stall);

    p_retire_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_ATOMIC && !sb_empty) |=> (cur_state == ST_ATOMIC));

    p_min_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && dispatch && k_bar) |=> (cur_state != ST_IDLE));
endmodule

bind fence_dispatch_gate fgate_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_kind     (in_kind),
    .sb_empty    (sb_empty),
    .dispatch    (dispatch),
    .alloc_stall (alloc_stall),
    .cur_state   (cur_state)
);

// File: tb/fence_dispatch_gate_test.sv
`timescale 1ns/1ps
module fence_dispatch_gate_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [2:0] in_kind;
    logic       hold_loads_only;
    logic       sb_empty;
    logic       bar_retire;
    logic       in_ready;
    logic       dispatch;
    logic       alloc_stall;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    fence_dispatch_gate uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .hold_loads_only(hold_loads_only), .sb_empty(sb_empty), .bar_retire(bar_retire),
        .in_ready(in_ready), .dispatch(dispatch), .alloc_stall(alloc_stall)
    );

    function automatic bit is_mem(int k);
        return (k >= 1 && k <= 5);
    endfunction

    // pend: 0 none, 3 atomic, 4 store-load barrier, 5 full fence unretired, 6 fence retired
    function automatic bit exp_ready(int pend, int k, bit mode);
        case (pend)
            0:       return 1'b1;
            4:       return mode ? !(k == 1 || k >= 3 && k <= 5) : !is_mem(k);
            5:       return 1'b0;
            default: return !is_mem(k);
        endcase
    endfunction

    function automatic string tag_for(int pend, int k, bit mode);
        if (k >= 3 && k <= 5) return "R9";
        if (pend == 4 && k == 2) return mode ? "R4 R11 R10" : "R3 R11 R10";
        if (pend == 4) return mode ? "R4 R10" : "R3 R10";
        if (pend == 3) return "R5 R10";
        if (pend == 6) return "R7";
        return "R6";
    endfunction

    task automatic chk(string req, logic g, logic s, logic eg, logic es);
        n_chk++;
        if (g !== eg || s !== es) begin
            n_bad++;
            $display("FAIL %s: dispatch=%b stall=%b expected dispatch=%b stall=%b", req, g, s, eg, es);
        end
    endtask

    task automatic cyc(logic v, int k, logic sb, logic rt, logic m, string req, bit er);
        in_valid = v; in_kind = 3'(k); sb_empty = sb; bar_retire = rt; hold_loads_only = m;
        @(negedge clk);
        chk(req, dispatch, alloc_stall, v & er, v & ~er);
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_kind = 3'd1;
        hold_loads_only = 1'b0; sb_empty = 1'b0; bar_retire = 1'b0;
        @(negedge clk);
        chk("R1 in reset", dispatch, alloc_stall, 1'b1, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) cyc(1, k, 0, 0, 0, "R1 after reset", 1);

        for (int b = 3; b <= 5; b++) begin
            for (int m = 0; m < 2; m++) begin
                cyc(1, b, 1, 0, m[0], "R2 barrier enters", 1);
                cyc(1, 1, 0, 0, m[0], "R12 next-cycle load", 0);
                for (int k = 0; k < 8; k++)
                    cyc(1, k, 0, (b != 5), ~m[0], tag_for(b, k, m[0]), exp_ready(b, k, m[0]));
                if (b != 5) begin
                    cyc(1, 1, 1, 0, m[0], "R8 clearing cycle", 0);
                    cyc(1, 1, 0, 0, m[0], "R8 resumed", 1);
                end else begin
                    cyc(1, 0, 1, 0, m[0], "R6 drained not retired", 0);
                    if (m == 0) begin
                        cyc(1, 0, 0, 1, m[0], "R6 retire cycle", 0);
                        for (int k = 0; k < 8; k++)
                            cyc(1, k, 0, 0, m[0], tag_for(6, k, m[0]), exp_ready(6, k, m[0]));
                        cyc(1, 2, 1, 0, m[0], "R8 drain cycle", 0);
                        cyc(1, 2, 0, 0, m[0], "R8 resumed", 1);
                    end else begin
                        cyc(1, 1, 1, 1, m[0], "R8 retire with empty", 0);
                        cyc(1, 1, 0, 0, m[0], "R8 resumed", 1);
                    end
                end
            end
        end

        // retire pulse in idle must not pre-credit a later fence
        cyc(1, 0, 0, 1, 0, "R10 idle retire", 1);
        cyc(1, 5, 1, 0, 0, "R2 fence enters", 1);
        cyc(1, 0, 1, 0, 0, "R10 earlier retire not counted", 0);
        cyc(1, 0, 1, 1, 0, "R8 fence retires", 0);
        cyc(1, 0, 0, 0, 0, "R8 resumed", 1);

        // reset while an atomic is pending
        cyc(1, 3, 0, 0, 0, "R2 atomic enters", 1);
        cyc(1, 1, 0, 0, 0, "R5 load held", 0);
        rst_n = 1'b0; in_valid = 1'b1; in_kind = 3'd1;
        @(negedge clk);
        chk("R1 reset clears pending", dispatch, alloc_stall, 1'b1, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cyc(1, 2, 0, 0, 0, "R1 store after reset", 1);

        done = 1;
        summary();
        $finish;
    end
endmodule